// File: doc/BRIEF.md
# Serial Communication Unit with Break Handling

This block is a character-oriented serial transceiver controlled through a small register window. In asynchronous mode it sends and receives frames built from a low start bit, eight data bits least significant bit first, an optional even parity bit and a high stop bit. Every bit lasts `OSR` clocks, and the receiver samples each bit in its middle. In clocked synchronous mode the transmitter sends eight data bits with no framing and drives a serial clock beside them. Baud-rate generation lies outside the block: one clock is one oversampling tick.

When transmit is disabled, the TxD pin is driven by a general-purpose port bit. A data bit sets its level and a direction bit sets its output enable. Software uses this to park the line in mark state, or to send a break by dropping transmit-enable in the middle of a frame. The receiver keeps framing through a held low line, so the framing error comes back after software clears it. Error flags are sticky. In synchronous mode, a pending error holds back the start of the next transmission. The block comes out of reset stopped and ignores its other registers until the stop bit is cleared.

Register map (address: content). 0 is STOP, bit 0, reset value 1. 1 is CTRL: bit 0 transmit-enable, bit 1 receive-enable, bit 2 synchronous mode, bit 3 parity enable. 2 is TXDATA. 3 is RXDATA. 4 is STATUS: bit 0 transmit buffer empty, bit 1 receive buffer full, bit 2 overrun, bit 3 framing error, bit 4 parity error, bit 5 synchronized RxD level. 5 is PORT: bit 0 data, bit 1 direction.

Top module: `ser_unit`

## Requirements
- R1: After reset STOP reads 1. While STOP is 1, writes to addresses 1 to 5 are ignored and reads of those addresses return 0. Writing 0 to STOP bit 0 opens access.
- R2: With CTRL bit 0 set and TXDATA written, the block sends a start bit 0, then eight data bits LSB first, then the even parity bit (XOR of the data) when CTRL bit 3 is set, then a stop bit 1. Each bit lasts OSR clocks. STATUS bit 0 returns to 1 once the character is taken.
- R3: While CTRL bit 0 is 0, txd_o equals PORT bit 0 and txd_oe_o equals PORT bit 1. While CTRL bit 0 is 1, txd_oe_o is 1 and an idle line is high.
- R4: Clearing CTRL bit 0 mid-frame aborts the transmitter at once: txd_o follows PORT from the next cycle. Enabling again does not resume the aborted character.
- R5: With CTRL bit 1 set, a received asynchronous frame places its data in RXDATA and sets STATUS bit 1. A read of RXDATA with rd_i clears STATUS bit 1.
- R6: A stop bit sampled low sets STATUS bit 3. When CTRL bit 3 is set, a parity bit that differs from the XOR of the data sets STATUS bit 4.
- R7: A continuous low on RxD sets STATUS bit 3. If software clears it while the line stays low, it is set again within one frame time.
- R8: A frame that completes while STATUS bit 1 is still 1 sets STATUS bit 2. The new character is discarded and RXDATA keeps the old one.
- R9: Error flags (STATUS bits 2 to 4) clear only when 1 is written to the matching STATUS bit. Clearing CTRL bit 1 leaves them unchanged. A flag set in the same cycle as its clear stays set.
- R10: With CTRL bit 2 set, the transmitter sends eight data bits LSB first with no start, parity or stop bit. sclk_o is low in the first half of each bit and high in the second half, and high when idle.
- R11: With CTRL bit 2 set, no transmission starts while any of STATUS bits 2 to 4 is set. STATUS bit 0 stays 0 and the line stays idle until the flags are cleared.
- R12: STATUS bit 5 gives the RxD level after a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one oversampling tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (pops RXDATA) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line level |
| txd_oe_o | output | 1 | Transmit pin output enable |
| sclk_o | output | 1 | Serial clock in synchronous mode |

## Verification
A register write takes effect at the clock edge that ends it. So the TxD mux, flag clears and abort results are checked at the falling edge right after the write. A transmit start follows one edge later, and the bench finds the start bit or the first low sclk_o level and then samples every following bit at its centre. Receive results arrive two synchronizer cycles plus half a bit after the start edge plus nine or ten bit times. The bench therefore checks status a few cycles after it finishes driving a stop bit. Break re-flagging is checked one full frame time (12·OSR cycles) after a clear. Blocking in synchronous mode is checked by watching the line for three bit times.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [2:0] {
    A_STOP = 3'd0, A_CTRL = 3'd1, A_TXD = 3'd2,
    A_RXD  = 3'd3, A_STAT = 3'd4, A_PORT = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic par_en;
    logic sync_mode;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;
endpackage

// File: rtl/ser_regs.sv
module ser_regs
  import ser_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       tx_take_i,
  input  logic       rx_done_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_fer_i,
  input  logic       rx_per_i,
  input  logic       rxd_s_i,
  output ctrl_t      ctrl_o,
  output logic       port_dat_o,
  output logic       port_dir_o,
  output logic       tx_have_o,
  output logic [7:0] tx_data_o,
  output logic       err_any_o
);
  logic       stop_q, port_dat_q, port_dir_q;
  ctrl_t      ctrl_q;
  logic [7:0] tx_buf_q, rx_buf_q;
  logic       tx_empty_q, rx_full_q, ovr_q, fer_q, per_q;
  logic       acc, wr_ctrl, wr_txd, wr_stat, wr_port, rd_rxd;
  logic [7:0] clr;

  assign acc     = !stop_q;
  assign wr_ctrl = wr_i && acc && addr_i == A_CTRL;
  assign wr_txd  = wr_i && acc && addr_i == A_TXD;
  assign wr_stat = wr_i && acc && addr_i == A_STAT;
  assign wr_port = wr_i && acc && addr_i == A_PORT;
  assign rd_rxd  = rd_i && acc && addr_i == A_RXD;
  assign clr     = wr_stat ? wdata_i : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q     <= 1'b1;
      ctrl_q     <= '0;
      port_dat_q <= 1'b0;
      port_dir_q <= 1'b0;
      tx_buf_q   <= '0;
      tx_empty_q <= 1'b1;
      rx_buf_q   <= '0;
      rx_full_q  <= 1'b0;
      ovr_q      <= 1'b0;
      fer_q      <= 1'b0;
      per_q      <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_STOP) stop_q <= wdata_i[0];
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[3:0]);
      if (wr_port) begin
        port_dat_q <= wdata_i[0];
        port_dir_q <= wdata_i[1];
      end
      if (wr_txd) begin
        tx_buf_q   <= wdata_i;
        tx_empty_q <= 1'b0;
      end else if (tx_take_i) begin
        tx_empty_q <= 1'b1;
      end
      // a new character never overwrites an unread one
      if (rx_done_i && !rx_full_q) begin
        rx_buf_q  <= rx_data_i;
        rx_full_q <= 1'b1;
      end else if (rd_rxd) begin
        rx_full_q <= 1'b0;
      end
      // set has priority over clear
      ovr_q <= (ovr_q & ~clr[2]) | (rx_done_i & rx_full_q);
      fer_q <= (fer_q & ~clr[3]) | (rx_done_i & rx_fer_i);
      per_q <= (per_q & ~clr[4]) | (rx_done_i & rx_per_i);
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == A_STOP) rdata_o = {7'b0, stop_q};
    else if (acc) begin
      case (addr_i)
        A_CTRL:  rdata_o = {4'b0, ctrl_q};
        A_TXD:   rdata_o = tx_buf_q;
        A_RXD:   rdata_o = rx_buf_q;
        A_STAT:  rdata_o = {2'b0, rxd_s_i, per_q, fer_q, ovr_q, rx_full_q, tx_empty_q};
        A_PORT:  rdata_o = {6'b0, port_dir_q, port_dat_q};
        default: rdata_o = 8'h00;
      endcase
    end
  end

  assign ctrl_o     = acc ? ctrl_q : '0;
  assign port_dat_o = port_dat_q;
  assign port_dir_o = port_dir_q;
  assign tx_have_o  = !tx_empty_q;
  assign tx_data_o  = tx_buf_q;
  assign err_any_o  = ovr_q | fer_q | per_q;

  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && addr_i != A_STOP) |-> rdata_o == 8'h00); // R1
  AST_FER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fer_q && !(wr_i && acc && addr_i == A_STAT && wdata_i[3])) |=> fer_q); // R9
  AST_OVR_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && rx_full_q) |=> $stable(rx_buf_q)); // R8
endmodule

// File: rtl/ser_tx.sv
module ser_tx
  import ser_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_en_i,
  input  logic       sync_i,
  input  logic       par_en_i,
  input  logic       have_data_i,
  input  logic       err_any_i,
  input  logic [7:0] data_i,
  output logic       take_o,
  output logic       line_o,
  output logic       sclk_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] HALF = CW'(OSR / 2);

  tx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bitn_q;
  logic [7:0]    sh_q;
  logic          par_q, par_en_q, sync_q, start_ok;

  assign start_ok = tx_en_i && have_data_i && state_q == TX_IDLE && !(sync_i && err_any_i);
  assign take_o   = start_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= TX_IDLE;
      cnt_q    <= '0;
      bitn_q   <= '0;
      sh_q     <= '0;
      par_q    <= 1'b0;
      par_en_q <= 1'b0;
      sync_q   <= 1'b0;
    end else if (!tx_en_i) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
    end else if (state_q == TX_IDLE) begin
      if (start_ok) begin
        sh_q     <= data_i;
        par_q    <= ^data_i;
        par_en_q <= par_en_i;
        sync_q   <= sync_i;
        cnt_q    <= '0;
        bitn_q   <= '0;
        state_q  <= sync_i ? TX_DATA : TX_START;
      end
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
      case (state_q)
        TX_START: state_q <= TX_DATA;
        TX_DATA: begin
          sh_q   <= {1'b0, sh_q[7:1]};
          bitn_q <= bitn_q + 1'b1;
          if (bitn_q == 3'd7)
            state_q <= sync_q ? TX_IDLE : (par_en_q ? TX_PAR : TX_STOP);
        end
        TX_PAR:  state_q <= TX_STOP;
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      TX_START: line_o = 1'b0;
      TX_DATA:  line_o = sh_q[0];
      TX_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  assign sclk_o = (state_q == TX_DATA && sync_q) ? (cnt_q >= HALF) : 1'b1;

  AST_TX_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> state_q == TX_IDLE); // R4
  AST_SYNC_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && sync_i && err_any_i && state_q == TX_IDLE) |=> state_q == TX_IDLE); // R11
endmodule

// File: rtl/ser_rx.sv
module ser_rx
  import ser_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       par_en_i,
  input  logic       rxd_i,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       fer_o,
  output logic       per_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bitn_q;
  logic [7:0]    sh_q;
  logic          par_en_q, par_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      bitn_q    <= '0;
      sh_q      <= '0;
      par_en_q  <= 1'b0;
      par_bit_q <= 1'b0;
      done_o    <= 1'b0;
      data_o    <= '0;
      fer_o     <= 1'b0;
      per_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          RX_IDLE: if (!rxd_i) begin
            state_q  <= RX_START;
            cnt_q    <= '0;
            par_en_q <= par_en_i;
          end
          RX_START: if (cnt_q == MID) begin
            cnt_q   <= '0;
            bitn_q  <= '0;
            state_q <= rxd_i ? RX_IDLE : RX_DATA;
          end else cnt_q <= cnt_q + 1'b1;
          RX_DATA: if (cnt_q == LAST) begin
            cnt_q  <= '0;
            sh_q   <= {rxd_i, sh_q[7:1]};
            bitn_q <= bitn_q + 1'b1;
            if (bitn_q == 3'd7) state_q <= par_en_q ? RX_PAR : RX_STOP;
          end else cnt_q <= cnt_q + 1'b1;
          RX_PAR: if (cnt_q == LAST) begin
            cnt_q     <= '0;
            par_bit_q <= rxd_i;
            state_q   <= RX_STOP;
          end else cnt_q <= cnt_q + 1'b1;
          default: if (cnt_q == LAST) begin
            // re-arm at once so a held low line keeps framing
            cnt_q   <= '0;
            done_o  <= 1'b1;
            data_o  <= sh_q;
            fer_o   <= !rxd_i;
            per_o   <= par_en_q && (par_bit_q != ^sh_q);
            state_q <= RX_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        endcase
      end
    end
  end

  AST_RX_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
endmodule

// File: rtl/ser_unit.sv
module ser_unit
  import ser_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rxd_i,
  output logic       txd_o,
  output logic       txd_oe_o,
  output logic       sclk_o
);
  ctrl_t      ctrl;
  logic       port_dat, port_dir, tx_have, err_any, tx_take, tx_line;
  logic       rx_done, rx_fer, rx_per;
  logic [7:0] tx_data, rx_data;
  logic [1:0] rxd_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rxd_sync_q <= 2'b11;
    else         rxd_sync_q <= {rxd_sync_q[0], rxd_i};
  end

  ser_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o,
    .tx_take_i (tx_take),
    .rx_done_i (rx_done),
    .rx_data_i (rx_data),
    .rx_fer_i  (rx_fer),
    .rx_per_i  (rx_per),
    .rxd_s_i   (rxd_sync_q[1]),
    .ctrl_o    (ctrl),
    .port_dat_o(port_dat),
    .port_dir_o(port_dir),
    .tx_have_o (tx_have),
    .tx_data_o (tx_data),
    .err_any_o (err_any)
  );

  ser_tx #(.OSR(OSR)) u_tx (
    .clk_i, .rst_ni,
    .tx_en_i    (ctrl.tx_en),
    .sync_i     (ctrl.sync_mode),
    .par_en_i   (ctrl.par_en),
    .have_data_i(tx_have),
    .err_any_i  (err_any),
    .data_i     (tx_data),
    .take_o     (tx_take),
    .line_o     (tx_line),
    .sclk_o     (sclk_o)
  );

  ser_rx #(.OSR(OSR)) u_rx (
    .clk_i, .rst_ni,
    .en_i    (ctrl.rx_en),
    .par_en_i(ctrl.par_en),
    .rxd_i   (rxd_sync_q[1]),
    .done_o  (rx_done),
    .data_o  (rx_data),
    .fer_o   (rx_fer),
    .per_o   (rx_per)
  );

  // port bit owns the pin whenever the transmitter is off
  assign txd_o    = ctrl.tx_en ? tx_line : port_dat;
  assign txd_oe_o = ctrl.tx_en ? 1'b1    : port_dir;

  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.tx_en && !$past(ctrl.tx_en) && !tx_have) |-> txd_o); // R3
endmodule

// File: tb/sim_ser_unit.sv
module sim_ser_unit;
  localparam int OSR = 16;
  logic clk_i = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, rd_i = 1'b0, rxd_i = 1'b1;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic txd_o, txd_oe_o, sclk_o;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  ser_unit #(.OSR(OSR)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; #1 d = rdata_o;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk_i); addr_i = 3'd3; rd_i = 1'b1; #1 d = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] d, input bit par, input bit bad_par, input bit bad_stop);
    @(negedge clk_i); rxd_i = 1'b0;
    repeat (OSR) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      rxd_i = d[i]; repeat (OSR) @(negedge clk_i);
    end
    if (par) begin
      rxd_i = (^d) ^ bad_par; repeat (OSR) @(negedge clk_i);
    end
    rxd_i = !bad_stop; repeat (OSR) @(negedge clk_i);
    rxd_i = 1'b1; repeat (6) @(negedge clk_i);
  endtask

  task automatic cap_async(input bit par, output logic [7:0] d, output logic p,
                           output logic stp, output bit ok);
    int t = 0;
    ok = 1'b1; d = '0; p = 1'b0; stp = 1'b0;
    while (txd_o !== 1'b0 && t < 40 * OSR) begin @(negedge clk_i); t++; end
    if (txd_o !== 1'b0) begin ok = 1'b0; return; end
    repeat (OSR / 2) @(negedge clk_i);
    if (txd_o !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (OSR) @(negedge clk_i); d[i] = txd_o;
    end
    if (par) begin repeat (OSR) @(negedge clk_i); p = txd_o; end
    repeat (OSR) @(negedge clk_i); stp = txd_o;
    repeat (OSR) @(negedge clk_i);
  endtask

  task automatic cap_sync(output logic [7:0] d, output logic hi, output bit ok);
    int t = 0;
    ok = 1'b1; d = '0; hi = 1'b0;
    while (sclk_o !== 1'b0 && t < 40 * OSR) begin @(negedge clk_i); t++; end
    if (sclk_o !== 1'b0) begin ok = 1'b0; return; end
    repeat (OSR / 4) @(negedge clk_i); d[0] = txd_o;
    repeat (OSR / 2) @(negedge clk_i); hi = sclk_o;
    repeat (OSR / 2) @(negedge clk_i);
    for (int i = 1; i < 8; i++) begin
      d[i] = txd_o; repeat (OSR) @(negedge clk_i);
    end
    repeat (OSR) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, d;
    logic p, stp, hi;
    bit ok;
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h6E};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: stopped after reset, access locked
    rd(3'd0, v); chk("R1 stop reset", v, 8'h01);
    rd(3'd4, v); chk("R1 stat hidden", v, 8'h00);
    chk("R3 oe reset", txd_oe_o, 1'b0);
    wr(3'd1, 8'h03);
    wr(3'd0, 8'h00);
    rd(3'd1, v); chk("R1 write ignored", v, 8'h00);
    rd(3'd4, v); chk("R1 stat open", v, 8'h21);
    // R3: port drives the pin
    wr(3'd5, 8'h03); chk("R3 mark level", txd_o, 1'b1); chk("R3 mark oe", txd_oe_o, 1'b1);
    wr(3'd5, 8'h01); chk("R3 dir off", txd_oe_o, 1'b0);
    wr(3'd5, 8'h02); chk("R3 low level", txd_o, 1'b0);
    wr(3'd1, 8'h01);
    chk("R3 idle high", txd_o, 1'b1); chk("R3 oe on", txd_oe_o, 1'b1);
    // R2: async transmit sweep, with and without parity
    for (int pe = 0; pe < 2; pe++) begin
      wr(3'd1, pe ? 8'h09 : 8'h01);
      foreach (pats[k]) begin
        wr(3'd2, pats[k]);
        cap_async(pe[0], d, p, stp, ok);
        chk("R2 start found", ok, 1'b1);
        chk("R2 data", d, pats[k]);
        if (pe) chk("R2 parity", p, ^pats[k]);
        chk("R2 stop", stp, 1'b1);
        rd(3'd4, v); chk("R2 tx empty", v[0], 1'b1);
      end
    end
    // R4: abort mid-frame into break
    wr(3'd1, 8'h01); wr(3'd5, 8'h02); wr(3'd2, 8'h55);
    begin
      int t = 0;
      while (txd_o !== 1'b0 && t < 4 * OSR) begin @(negedge clk_i); t++; end
    end
    repeat (3 * OSR) @(negedge clk_i);
    wr(3'd1, 8'h00);
    chk("R4 break level", txd_o, 1'b0); chk("R4 break oe", txd_oe_o, 1'b1);
    repeat (2 * OSR) @(negedge clk_i);
    chk("R4 break held", txd_o, 1'b0);
    wr(3'd5, 8'h03); chk("R4 port mark", txd_o, 1'b1);
    wr(3'd1, 8'h01);
    begin
      bit seen_low = 1'b0;
      for (int i = 0; i < 12 * OSR; i++) begin
        @(negedge clk_i); if (txd_o !== 1'b1) seen_low = 1'b1;
      end
      chk("R4 no resume", seen_low, 1'b0);
    end
    rd(3'd4, v); chk("R4 empty after abort", v[0], 1'b1);
    // R5: receive sweep
    wr(3'd1, 8'h02);
    foreach (pats[k]) begin
      send_rx(pats[k], 1'b0, 1'b0, 1'b0);
      rd(3'd4, v); chk("R5 full", v[1], 1'b1); chk("R6 no fer", v[3], 1'b0);
      pop(d); chk("R5 data", d, pats[k]);
      rd(3'd4, v); chk("R5 full cleared", v[1], 1'b0);
    end
    // R6: parity and framing
    wr(3'd1, 8'h0A);
    send_rx(8'hC3, 1'b1, 1'b0, 1'b0); pop(d);
    rd(3'd4, v); chk("R6 good parity", v[4], 1'b0); chk("R6 parity data", d, 8'hC3);
    send_rx(8'hC3, 1'b1, 1'b1, 1'b0); pop(d);
    rd(3'd4, v); chk("R6 bad parity", v[4], 1'b1);
    wr(3'd4, 8'h10); rd(3'd4, v); chk("R9 per cleared", v[4], 1'b0);
    wr(3'd1, 8'h02);
    send_rx(8'h5A, 1'b0, 1'b0, 1'b1); pop(d);
    rd(3'd4, v); chk("R6 bad stop", v[3], 1'b1);
    wr(3'd4, 8'h08); rd(3'd4, v); chk("R9 fer cleared", v[3], 1'b0);
    // R8: overrun keeps first character
    send_rx(8'h11, 1'b0, 1'b0, 1'b0);
    send_rx(8'h22, 1'b0, 1'b0, 1'b0);
    rd(3'd4, v); chk("R8 overrun", v[2], 1'b1);
    pop(d); chk("R8 old kept", d, 8'h11);
    wr(3'd4, 8'h04); rd(3'd4, v); chk("R9 ovr cleared", v[2], 1'b0);
    // R7: break and re-flag
    @(negedge clk_i); rxd_i = 1'b0;
    repeat (12 * OSR) @(negedge clk_i);
    rd(3'd4, v); chk("R7 break fer", v[3], 1'b1); chk("R12 rxd low", v[5], 1'b0);
    wr(3'd4, 8'h08); rd(3'd4, v); chk("R7 fer cleared", v[3], 1'b0);
    repeat (12 * OSR) @(negedge clk_i);
    rd(3'd4, v); chk("R7 fer re-set", v[3], 1'b1);
    wr(3'd1, 8'h00);
    rd(3'd4, v); chk("R9 rx off keeps fer", v[3], 1'b1);
    @(negedge clk_i); rxd_i = 1'b1;
    repeat (4) @(negedge clk_i);
    rd(3'd4, v); chk("R12 rxd high", v[5], 1'b1);
    // R11: sync transmit blocked by pending error
    wr(3'd1, 8'h05); wr(3'd2, 8'h96);
    begin
      bit moved = 1'b0;
      for (int i = 0; i < 3 * OSR; i++) begin
        @(negedge clk_i); if (sclk_o !== 1'b1 || txd_o !== 1'b1) moved = 1'b1;
      end
      chk("R11 held idle", moved, 1'b0);
    end
    rd(3'd4, v); chk("R11 not taken", v[0], 1'b0);
    // R10: release and capture synchronous data
    wr(3'd4, 8'h1C);
    cap_sync(d, hi, ok);
    chk("R10 sclk seen", ok, 1'b1);
    chk("R10 sync data", d, 8'h96);
    chk("R10 sclk high half", hi, 1'b1);
    chk("R10 sclk idle", sclk_o, 1'b1);
    rd(3'd4, v); chk("R11 taken after clear", v[0], 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule